// File: doc/BRIEF.md
# Outbound Packet Descriptor/Data Sequencer

This block sits on the application side of a link-layer core. It takes outbound transaction-layer packets from a local command port and hands them to the core over a split handshake. The core first sees a request that carries a 128-bit header descriptor. For packets with a payload, a data phase then streams 64-bit beats, and that phase overlaps the descriptor phase under strict cycle rules. The block serves one virtual channel.

A command is a single descriptor word. The block takes whether a payload exists, and its length in doublewords, from fields of that descriptor. Payload words come from a show-ahead FIFO. The head word appears on `pl_data_i`, and the block pops it with `pl_pop_o` when the core takes the beat. The core acknowledges the descriptor with a one-cycle pulse and throttles the data with a wait-state input. The command port reports ready while idle and in the cycle a packet completes. A new descriptor can therefore follow the acknowledge of a payload-free packet with no gap.

Top module: `tx_pkt_seq`

## Requirements
- R1: While reset is asserted (active-low, asynchronous), and after reset until a command is taken, `core_req_o`, `core_desc_o`, `core_frame_o`, `core_dv_o`, `core_data_o` and `pl_pop_o` are all zero and `cmd_ready_o` is high.
- R2: A command taken at a clock edge (`cmd_valid_i` and `cmd_ready_o` both high) makes `core_req_o` high on the next cycle, with `core_desc_o` equal to the command descriptor. Both hold unchanged until the cycle in which `core_ack_i` is high.
- R3: Descriptor bit 126 is the payload flag (1 = payload). With the flag set, `core_frame_o` rises in the same cycle as `core_req_o`. With the flag clear, `core_frame_o` and `core_dv_o` stay low for the whole packet.
- R4: `core_dv_o` rises one cycle after `core_frame_o` first rises, and stays high until the last beat is accepted. It is low on the following cycle.
- R5: `core_frame_o` is high during every data-phase cycle before the one that presents the last beat. It is low while the last beat is presented.
- R6: A beat is accepted exactly when `core_dv_o` is high and `core_wait_i` is low. `pl_pop_o` pulses in that cycle, `core_data_o` equals `pl_data_i` while `core_dv_o` is high, and an unaccepted beat is presented again.
- R7: `core_wait_i` has no effect while `core_dv_o` is low: no pop, and no beat is consumed.
- R8: Bits 105:96 give the length in doublewords, and a value of 0 means 1024. The packet sends ceil(length/2) beats.
- R9: `core_req_o` falls on the cycle after the acknowledge, unless a command is taken in the acknowledge cycle. In that case `core_req_o` stays high and `core_desc_o` carries the new descriptor.
- R10: `cmd_ready_o` is high when idle, and in the cycle a packet completes: the acknowledge cycle of a payload-free packet, or the cycle its last beat is accepted once it has been acknowledged. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_desc_i | input | 128 | Command header descriptor |
| cmd_ready_o | output | 1 | Command can be taken this cycle |
| pl_data_i | input | 64 | Payload FIFO head word |
| pl_pop_o | output | 1 | Pop payload FIFO head |
| core_req_o | output | 1 | Descriptor request to core |
| core_desc_o | output | 128 | Descriptor presented to core |
| core_ack_i | input | 1 | Descriptor acknowledge pulse |
| core_frame_o | output | 1 | Data-phase framing |
| core_dv_o | output | 1 | Data beat valid |
| core_wait_i | input | 1 | Wait state from core |
| core_data_o | output | 64 | Data beat to core |

## Verification
The hardest state to reach is a packet that completes in the same cycle a new descriptor is taken. The bench gets there by holding a second command valid while a payload-free packet is acknowledged, then checks that the request stays high with the new descriptor. A second hard case is a first beat accepted in the acknowledge cycle. The core model releases its wait state early only for packets whose format bit 125 marks a 3-doubleword header, so that case arises. Wait states toggle while valid is low, and odd lengths and the zero-means-1024 length cover the final-beat framing.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;
  localparam int unsigned TXS_DESC_W      = 128;
  localparam int unsigned TXS_DATA_W      = 64;
  localparam int unsigned TXS_LEN_W       = 10;
  localparam int unsigned TXS_HASDATA_BIT = 126;
  localparam int unsigned TXS_LEN_LSB     = 96;
endpackage

// File: rtl/txs_desc_slot.sv
module txs_desc_slot #(
  parameter int unsigned DESC_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DESC_W-1:0] desc_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [DESC_W-1:0] desc_o
);
  logic              req_q;
  logic [DESC_W-1:0] desc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      desc_q <= '0;
    end else if (load_i) begin
      req_q  <= 1'b1;
      desc_q <= desc_i;
    end else if (req_q && ack_i) begin
      req_q  <= 1'b0;
    end
  end

  assign req_o  = req_q;
  assign desc_o = desc_q;

  assert_desc_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i) |=> (req_q && $stable(desc_q)));
endmodule

// File: rtl/txs_beat_seq.sv
module txs_beat_seq #(
  parameter int unsigned LEN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             has_data_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             wait_i,
  output logic             frame_o,
  output logic             dv_o,
  output logic             accept_o,
  output logic             last_o
);
  localparam int unsigned BEAT_W = LEN_W + 1;

  logic              active_q;
  logic              dv_q;
  logic [BEAT_W-1:0] left_q;
  logic [LEN_W:0]    dw_count;
  logic [BEAT_W-1:0] beats;
  logic              accept;
  logic              is_last;

  // zero length field encodes the maximum size
  always_comb begin
    dw_count = (len_i == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, len_i};
    beats    = BEAT_W'(({1'b0, dw_count} + (LEN_W+2)'(1)) >> 1);
  end

  assign accept  = dv_q && !wait_i;
  assign is_last = (left_q == BEAT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      dv_q     <= 1'b0;
      left_q   <= '0;
    end else if (load_i) begin
      active_q <= has_data_i;
      dv_q     <= 1'b0;
      left_q   <= beats;
    end else begin
      if (active_q && !dv_q) dv_q <= 1'b1;
      if (accept) begin
        if (is_last) begin
          active_q <= 1'b0;
          dv_q     <= 1'b0;
        end else begin
          left_q <= left_q - BEAT_W'(1);
        end
      end
    end
  end

  assign frame_o  = active_q && (!dv_q || !is_last);
  assign dv_o     = dv_q;
  assign accept_o = accept;
  assign last_o   = accept && is_last;

  assert_frame_before_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dv_q) |-> !$past(frame_o));
  assert_beats_in_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dv_q |-> (left_q != '0));
endmodule

// File: rtl/tx_pkt_seq.sv
module tx_pkt_seq
  import tx_seq_pkg::*;
#(
  parameter int unsigned DESC_W      = TXS_DESC_W,
  parameter int unsigned DATA_W      = TXS_DATA_W,
  parameter int unsigned LEN_W       = TXS_LEN_W,
  parameter int unsigned HASDATA_BIT = TXS_HASDATA_BIT,
  parameter int unsigned LEN_LSB     = TXS_LEN_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [DESC_W-1:0] cmd_desc_i,
  output logic              cmd_ready_o,
  input  logic [DATA_W-1:0] pl_data_i,
  output logic              pl_pop_o,
  output logic              core_req_o,
  output logic [DESC_W-1:0] core_desc_o,
  input  logic              core_ack_i,
  output logic              core_frame_o,
  output logic              core_dv_o,
  input  logic              core_wait_i,
  output logic [DATA_W-1:0] core_data_o
);
  logic busy_q, acked_q;
  logic load, ack_seen, data_pend, fin;
  logic frame, dv, accept, last;

  txs_desc_slot #(.DESC_W(DESC_W)) u_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .desc_i (cmd_desc_i),
    .ack_i  (core_ack_i),
    .req_o  (core_req_o),
    .desc_o (core_desc_o)
  );

  txs_beat_seq #(.LEN_W(LEN_W)) u_beats (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .has_data_i (cmd_desc_i[HASDATA_BIT]),
    .len_i      (cmd_desc_i[LEN_LSB +: LEN_W]),
    .wait_i     (core_wait_i),
    .frame_o    (frame),
    .dv_o       (dv),
    .accept_o   (accept),
    .last_o     (last)
  );

  assign ack_seen  = acked_q || (core_ack_i && core_req_o);
  assign data_pend = frame || dv;
  assign fin       = busy_q && ack_seen && (!data_pend || last);

  assign cmd_ready_o = !busy_q || fin;
  assign load        = cmd_valid_i && cmd_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      acked_q <= 1'b0;
    end else if (load) begin
      busy_q  <= 1'b1;
      acked_q <= 1'b0;
    end else if (fin) begin
      busy_q  <= 1'b0;
      acked_q <= 1'b0;
    end else if (core_ack_i && core_req_o) begin
      acked_q <= 1'b1;
    end
  end

  assign core_frame_o = frame;
  assign core_dv_o    = dv;
  assign pl_pop_o     = accept;
  assign core_data_o  = dv ? pl_data_i : '0;

  assert_frame_with_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_req_o && !core_desc_o[HASDATA_BIT]) |-> (!core_frame_o && !core_dv_o));
  assert_dv_follows_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_frame_o) |=> core_dv_o);
  assert_req_drops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_req_o && core_ack_i && !(cmd_valid_i && cmd_ready_o)) |=> !core_req_o);
  assert_pop_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_dv_o |-> !pl_pop_o);
endmodule

// File: tb/tx_pkt_seq_tb.sv
module tx_pkt_seq_tb;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cmd_valid_i = 1'b0;
  logic [127:0] cmd_desc_i = '0;
  logic         cmd_ready_o;
  logic [63:0]  pl_data_i = '0;
  logic         pl_pop_o;
  logic         core_req_o;
  logic [127:0] core_desc_o;
  logic         core_ack_i = 1'b0;
  logic         core_frame_o;
  logic         core_dv_o;
  logic         core_wait_i = 1'b0;
  logic [63:0]  core_data_o;

  int checks = 0;
  int errors = 0;
  int pkt_no = 0;

  always #4ns clk = ~clk;

  tx_pkt_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid_i), .cmd_desc_i(cmd_desc_i), .cmd_ready_o(cmd_ready_o),
    .pl_data_i(pl_data_i), .pl_pop_o(pl_pop_o),
    .core_req_o(core_req_o), .core_desc_o(core_desc_o), .core_ack_i(core_ack_i),
    .core_frame_o(core_frame_o), .core_dv_o(core_dv_o), .core_wait_i(core_wait_i),
    .core_data_o(core_data_o)
  );

  localparam int NV = 7;
  localparam logic [9:0] T_LEN  [NV] = '{10'd1, 10'd2, 10'd3, 10'd8, 10'd0, 10'd5, 10'd7};
  localparam bit         T_DATA [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam bit         T_HDR3 [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam int         T_DLY  [NV] = '{0, 3, 1, 0, 2, 1, 5};
  localparam logic [7:0] T_WM   [NV] = '{8'h00, 8'h55, 8'h0f, 8'h92, 8'h00, 8'h00, 8'h7e};

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_beats(input logic [127:0] d);
    int dw;
    dw = (d[105:96] == 10'd0) ? 1024 : int'(d[105:96]);
    return d[126] ? (dw + 1) / 2 : 0;
  endfunction

  function automatic logic [63:0] pat(input int p, input int i);
    return {32'(p) ^ 32'hA5A5_0000, 32'(i)};
  endfunction

  function automatic logic [127:0] mk_desc(input logic [9:0] len, input bit hd, input bit hdr3, input int tag);
    logic [127:0] d;
    d = {4{32'(tag) * 32'h9E37_79B9}};
    d[126] = hd;
    d[125] = !hdr3;
    d[105:96] = len;
    return d;
  endfunction

  task automatic run_pkt(input logic [127:0] d, input int dly, input logic [7:0] wm);
    int beats, cyc, age, idx, bad_stab, bad_ready, bad_pop;
    bit hd, hdr3, acked, done, ack, wt, acc, fin_exp;
    beats = exp_beats(d); hd = d[126]; hdr3 = !d[125];
    cyc = 0; age = 0; idx = 0; bad_stab = 0; bad_ready = 0; bad_pop = 0;
    acked = 0; done = 0;
    pkt_no++;
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_desc_i = d; core_ack_i = 1'b0; core_wait_i = 1'b0;
    #1ns;
    chk(cmd_ready_o == 1'b1, "R10 ready when idle", 128'(cmd_ready_o), 128'd1);
    @(negedge clk);
    cmd_valid_i = 1'b0;
    while (!done && cyc < 3000) begin
      if (cyc != 0) @(negedge clk);
      ack = core_req_o && !acked && (age == dly);
      if (!core_dv_o) wt = cyc[0];
      else wt = !(acked || (ack && hdr3)) || wm[cyc % 8];
      core_ack_i = ack; core_wait_i = wt; pl_data_i = pat(pkt_no, idx);
      #1ns;
      if (cyc == 0) begin
        chk(core_req_o == 1'b1, "R2 request raised", 128'(core_req_o), 128'd1);
        chk(core_desc_o == d, "R2 descriptor presented", core_desc_o, d);
        chk(core_frame_o == hd, "R3 frame with request", 128'(core_frame_o), 128'(hd));
      end
      if (cyc == 1)
        chk(core_dv_o == (hd && idx < beats), "R4 valid one cycle after frame", 128'(core_dv_o), 128'(hd));
      if (core_req_o && !acked && core_desc_o != d) bad_stab++;
      acc = core_dv_o && !wt;
      if (pl_pop_o != acc) bad_pop++;
      if (acc) begin
        chk(core_data_o == pat(pkt_no, idx), "R6 beat data", 128'(core_data_o), 128'(pat(pkt_no, idx)));
        chk(core_frame_o == (idx != beats - 1), "R5 frame vs last beat", 128'(core_frame_o), 128'(idx != beats - 1));
        idx++;
      end
      fin_exp = (acked || ack) && (!hd || (acc && idx == beats));
      if (cmd_ready_o != fin_exp) bad_ready++;
      if (ack) acked = 1'b1;
      else if (core_req_o && !acked) age++;
      done = fin_exp;
      cyc++;
    end
    @(negedge clk);
    core_ack_i = 1'b0; core_wait_i = 1'b1; pl_data_i = pat(pkt_no, idx);
    #1ns;
    chk(core_req_o == 1'b0, "R9 request drops after ack", 128'(core_req_o), 128'd0);
    chk(core_dv_o == 1'b0 && pl_pop_o == 1'b0, "R7 wait ignored after packet", 128'({core_dv_o, pl_pop_o}), 128'd0);
    chk(cmd_ready_o == 1'b1, "R10 ready after completion", 128'(cmd_ready_o), 128'd1);
    chk(idx == beats, "R8 beat count", 128'(idx), 128'(beats));
    chk(bad_stab == 0, "R2 descriptor stable until ack", 128'(bad_stab), 128'd0);
    chk(bad_pop == 0, "R6 R7 pop only on dv and no wait", 128'(bad_pop), 128'd0);
    chk(bad_ready == 0, "R10 ready timing", 128'(bad_ready), 128'd0);
    core_wait_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] da, db;
    #1ns;
    chk({core_req_o, core_frame_o, core_dv_o, pl_pop_o} == 4'b0, "R1 outputs low in reset",
        128'({core_req_o, core_frame_o, core_dv_o, pl_pop_o}), 128'd0);
    chk(core_desc_o == '0 && core_data_o == '0, "R1 buses low in reset", core_desc_o, 128'd0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    core_wait_i = 1'b1;
    @(negedge clk); #1ns;
    chk(cmd_ready_o == 1'b1 && core_req_o == 1'b0 && pl_pop_o == 1'b0, "R1 R7 idle after reset",
        128'({cmd_ready_o, core_req_o, pl_pop_o}), 128'b100);
    core_wait_i = 1'b0;

    for (int v = 0; v < NV; v++)
      run_pkt(mk_desc(T_LEN[v], T_DATA[v], T_HDR3[v], v + 1), T_DLY[v], T_WM[v]);

    // back-to-back: new descriptor taken in the ack cycle of a payload-free packet
    da = mk_desc(10'd4, 1'b0, 1'b1, 40);
    db = mk_desc(10'd6, 1'b0, 1'b0, 41);
    @(negedge clk); cmd_valid_i = 1'b1; cmd_desc_i = da;
    @(negedge clk); cmd_valid_i = 1'b0;
    @(negedge clk); core_ack_i = 1'b1; cmd_valid_i = 1'b1; cmd_desc_i = db;
    #1ns;
    chk(cmd_ready_o == 1'b1, "R10 ready in ack cycle of payload-free packet", 128'(cmd_ready_o), 128'd1);
    @(negedge clk); core_ack_i = 1'b0; cmd_valid_i = 1'b0;
    #1ns;
    chk(core_req_o == 1'b1 && core_desc_o == db, "R9 back-to-back request keeps new descriptor", core_desc_o, db);
    chk(core_frame_o == 1'b0, "R3 no frame for payload-free packet", 128'(core_frame_o), 128'd0);
    @(negedge clk); core_ack_i = 1'b1;
    @(negedge clk); core_ack_i = 1'b0;
    #1ns;
    chk(core_req_o == 1'b0, "R9 request drops after second ack", 128'(core_req_o), 128'd0);

    // reset in the middle of a data phase
    @(negedge clk); cmd_valid_i = 1'b1; cmd_desc_i = mk_desc(10'd16, 1'b1, 1'b0, 50);
    @(negedge clk); cmd_valid_i = 1'b0; core_ack_i = 1'b1;
    @(negedge clk); core_ack_i = 1'b0;
    @(negedge clk); #1ns;
    chk(core_dv_o == 1'b1, "R4 valid during data phase", 128'(core_dv_o), 128'd1);
    rst_ni = 1'b0;
    #1ns;
    chk({core_req_o, core_frame_o, core_dv_o, pl_pop_o} == 4'b0 && core_data_o == '0,
        "R1 asynchronous reset clears outputs", 128'({core_req_o, core_frame_o, core_dv_o, pl_pop_o}), 128'd0);
    @(negedge clk); rst_ni = 1'b1;
    run_pkt(mk_desc(10'd2, 1'b1, 1'b1, 60), 0, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule